// File: doc/BRIEF.md
# Seven-to-one pixel link serializer

This block turns a 28-bit parallel pixel word into four serial data lanes and one framing clock lane for a display link. All logic runs on a single bit clock at seven times the pixel rate. A free-running phase counter divides each pixel period into seven bit slots. Every lane sends one bit per slot, so a whole word leaves in one pixel period.

The word is captured when a pixel strobe shows the edge picked by a select input. The select at 0 picks the falling edge, which is the usual setting. The captured word enters the lane shift registers only at the start of a pixel period, so a period never mixes two words. The 28 input bits are spread across the lanes in a fixed grouping that is not sequential. The clock lane is high for the first four slots of each period and low for the last three, which lets the receiver find the word boundary.

An active-low power-down input holds the transmitter quiet, as does the synchronous reset. When the block is enabled again, a fresh period starts at slot 0 on the next bit clock.

Top module: `pixlink_ser`

## Requirements
- R1: Each pixel period lasts exactly seven bit clocks, and every one of the four data lanes sends one bit in each of slots 0 to 6.
- R2: The clock lane is 1 in slots 0 to 3 and 0 in slots 4 to 6, so it rises exactly at the start of each period.
- R3: Data lane 0 (`lane_o[0]`) sends word bits 7, 6, 4, 3, 2, 1, 0 in slots 0 to 6.
- R4: Data lane 1 (`lane_o[1]`) sends word bits 18, 15, 14, 13, 12, 9, 8 in slots 0 to 6.
- R5: Data lane 2 (`lane_o[2]`) sends word bits 26, 25, 24, 22, 21, 20, 19 in slots 0 to 6.
- R6: Data lane 3 (`lane_o[3]`) sends word bits 23, 17, 16, 11, 10, 5, 27 in slots 0 to 6.
- R7: With `edge_sel`=1 the word is captured on a 0-to-1 change of `pix_strobe`. With `edge_sel`=0 it is captured on a 1-to-0 change. A change in the other direction leaves the captured word unchanged. The strobe and the word are sampled on the bit clock, and the word present at the clock edge that first sees the new strobe level is the one taken.
- R8: While `pwr_n` is 0, all lanes and the clock lane read 0 one clock later, the slot counter and the captured word are cleared, and strobe edges are ignored. On the first clock with `pwr_n`=1, slot 0 of a period is sent, carrying a word of zeros.
- R9: While `rst` is 1, all outputs read 0 one clock later and the captured word is cleared. On the first clock after release, slot 0 of a period is sent with zero data.
- R10: A word captured during a period does not alter the rest of that period. It is sent whole in the next period, starting at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock, seven times the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| pwr_n | input | 1 | Active-low power-down; 0 disables the transmitter |
| edge_sel | input | 1 | Strobe edge select: 1 rising, 0 falling |
| pix_strobe | input | 1 | Pixel strobe, sampled on bit_clk |
| pix_word | input | 28 | Parallel pixel word |
| lane_o | output | 4 | Serial data lanes, one bit per slot each |
| clk_lane_o | output | 1 | Framing clock lane, 4 slots high then 3 low |

## Verification
The checker watches several things on every clock. It holds the clock-lane shape after each rise, four highs then three lows. It checks that the slot counter stays in range and that the outputs are quiet after reset or power-down. It checks that slot 0 of each lane carries the word held by the capture stage. It checks that a strobe edge of the selected direction captures the word, while an edge of the other direction leaves the held word unchanged.

The full bit placement across slots 1 to 6 is only shown by the bench's walking-one and complement sweeps, which run in both edge modes. The same is true of the rule that a word captured mid-period waits for the next period. The restart at slot 0 after power-down and after a reset in mid-stream is also checked only by the bench.

// File: rtl/pixlink_pkg.sv
package pixlink_pkg;

  // Source bit index for each lane and slot, 5 bits per slot, slot 0 in the LSBs.
  localparam logic [34:0] LANE0_SRC = {5'd0,  5'd1,  5'd2,  5'd3,  5'd4,  5'd6,  5'd7};
  localparam logic [34:0] LANE1_SRC = {5'd8,  5'd9,  5'd12, 5'd13, 5'd14, 5'd15, 5'd18};
  localparam logic [34:0] LANE2_SRC = {5'd19, 5'd20, 5'd21, 5'd22, 5'd24, 5'd25, 5'd26};
  localparam logic [34:0] LANE3_SRC = {5'd27, 5'd5,  5'd10, 5'd11, 5'd16, 5'd17, 5'd23};

  function automatic int src_bit(input int lane, input int slot);
    logic [34:0] row;
    case (lane)
      0:       row = LANE0_SRC;
      1:       row = LANE1_SRC;
      2:       row = LANE2_SRC;
      default: row = LANE3_SRC;
    endcase
    return int'(row[5*slot +: 5]);
  endfunction

endpackage

// File: rtl/pixlink_phase.sv
module pixlink_phase #(
  parameter int SLOTS      = 7,
  parameter int HIGH_SLOTS = 4,
  localparam int SLOT_W    = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              clr,
  output logic [SLOT_W-1:0] slot,
  output logic              start,
  output logic              frame_q
);

  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);
  localparam logic [SLOT_W-1:0] HIGH = SLOT_W'(HIGH_SLOTS);

  logic [SLOT_W-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (clr) begin
      slot_q  <= '0;
      frame_q <= 1'b0;
    end else begin
      slot_q  <= (slot_q == LAST) ? '0 : slot_q + 1'b1;
      frame_q <= (slot_q < HIGH);
    end
  end

  assign slot  = slot_q;
  assign start = (slot_q == '0);

endmodule

// File: rtl/pixlink_capture.sv
module pixlink_capture #(
  parameter int WORD_W = 28
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              edge_sel,
  input  logic              strobe,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] word_q
);

  logic strobe_q;
  logic take;

  always_comb begin
    if (edge_sel) take = strobe & ~strobe_q;
    else          take = ~strobe & strobe_q;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      strobe_q <= 1'b0;
      word_q   <= '0;
    end else begin
      strobe_q <= strobe;
      if (take) word_q <= word_in;
    end
  end

endmodule

// File: rtl/pixlink_lane.sv
module pixlink_lane #(
  parameter int LANE_IDX = 0,
  parameter int SLOTS    = 7,
  parameter int WORD_W   = 28
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic              bit_o
);

  logic [SLOTS-1:0] mapped;
  logic [SLOTS-2:0] sr;

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    localparam int SRC = pixlink_pkg::src_bit(LANE_IDX, k);
    assign mapped[k] = word[SRC];
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      sr    <= '0;
      bit_o <= 1'b0;
    end else if (load) begin
      bit_o <= mapped[0];
      sr    <= mapped[SLOTS-1:1];
    end else begin
      bit_o <= sr[0];
      sr    <= {1'b0, sr[SLOTS-2:1]};
    end
  end

endmodule

// File: rtl/pixlink_ser.sv
module pixlink_ser #(
  parameter int LANES      = 4,
  parameter int SLOTS      = 7,
  parameter int HIGH_SLOTS = 4,
  localparam int WORD_W    = LANES * SLOTS,
  localparam int SLOT_W    = $clog2(SLOTS)
) (
  input  logic              bit_clk,
  input  logic              rst,
  input  logic              pwr_n,
  input  logic              edge_sel,
  input  logic              pix_strobe,
  input  logic [WORD_W-1:0] pix_word,
  output logic [LANES-1:0]  lane_o,
  output logic              clk_lane_o
);

  logic              clr;
  logic              start;
  logic [SLOT_W-1:0] slot_idx;
  logic [WORD_W-1:0] cap_word;

  assign clr = rst | ~pwr_n;

  pixlink_phase #(.SLOTS(SLOTS), .HIGH_SLOTS(HIGH_SLOTS)) i_phase (
    .clk     (bit_clk),
    .clr     (clr),
    .slot    (slot_idx),
    .start   (start),
    .frame_q (clk_lane_o)
  );

  pixlink_capture #(.WORD_W(WORD_W)) i_capture (
    .clk      (bit_clk),
    .clr      (clr),
    .edge_sel (edge_sel),
    .strobe   (pix_strobe),
    .word_in  (pix_word),
    .word_q   (cap_word)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    pixlink_lane #(.LANE_IDX(l), .SLOTS(SLOTS), .WORD_W(WORD_W)) i_lane (
      .clk   (bit_clk),
      .clr   (clr),
      .load  (start),
      .word  (cap_word),
      .bit_o (lane_o[l])
    );
  end

endmodule

// File: rtl/pixlink_ser_chk.sv
module pixlink_ser_chk #(
  parameter int LANES      = 4,
  parameter int SLOTS      = 7,
  parameter int HIGH_SLOTS = 4,
  localparam int WORD_W    = LANES * SLOTS,
  localparam int SLOT_W    = $clog2(SLOTS)
) (
  input logic              bit_clk,
  input logic              rst,
  input logic              pwr_n,
  input logic              edge_sel,
  input logic              pix_strobe,
  input logic [WORD_W-1:0] pix_word,
  input logic [LANES-1:0]  lane_o,
  input logic              clk_lane_o,
  input logic [WORD_W-1:0] cap_word,
  input logic [SLOT_W-1:0] slot_idx
);

  AST_SLOT_BOUND: assert property (@(posedge bit_clk) disable iff (rst)
    slot_idx < SLOT_W'(SLOTS)); // R1

  AST_FRAME_SHAPE: assert property (@(posedge bit_clk) disable iff (rst || !pwr_n)
    $rose(clk_lane_o) |=> clk_lane_o ##1 clk_lane_o ##1 clk_lane_o
                          ##1 !clk_lane_o ##1 !clk_lane_o ##1 !clk_lane_o ##1 clk_lane_o); // R2

  for (genvar l = 0; l < LANES; l++) begin : g_first
    localparam int SRC = pixlink_pkg::src_bit(l, 0);
    AST_FIRST_SLOT_LOAD: assert property (@(posedge bit_clk) disable iff (rst || !pwr_n)
      $rose(clk_lane_o) |-> lane_o[l] == $past(cap_word[SRC])); // R10
  end

  AST_EDGE_TAKEN: assert property (@(posedge bit_clk) disable iff (rst || !pwr_n)
    ($past(pwr_n) && !$past(rst) &&
     ((edge_sel && pix_strobe && !$past(pix_strobe)) ||
      (!edge_sel && !pix_strobe && $past(pix_strobe))))
    |=> cap_word == $past(pix_word)); // R7

  AST_EDGE_IGNORED: assert property (@(posedge bit_clk) disable iff (rst || !pwr_n)
    ($past(pwr_n) && !$past(rst) &&
     ((edge_sel && !pix_strobe && $past(pix_strobe)) ||
      (!edge_sel && pix_strobe && !$past(pix_strobe))))
    |=> $stable(cap_word)); // R7

  AST_OFF_QUIET: assert property (@(posedge bit_clk)
    !pwr_n |=> (lane_o == '0 && !clk_lane_o && slot_idx == '0 && cap_word == '0)); // R8

  AST_RST_QUIET: assert property (@(posedge bit_clk)
    rst |=> (lane_o == '0 && !clk_lane_o && slot_idx == '0 && cap_word == '0)); // R9

endmodule

bind pixlink_ser pixlink_ser_chk #(
  .LANES(LANES), .SLOTS(SLOTS), .HIGH_SLOTS(HIGH_SLOTS)
) i_chk (
  .bit_clk    (bit_clk),
  .rst        (rst),
  .pwr_n      (pwr_n),
  .edge_sel   (edge_sel),
  .pix_strobe (pix_strobe),
  .pix_word   (pix_word),
  .lane_o     (lane_o),
  .clk_lane_o (clk_lane_o),
  .cap_word   (cap_word),
  .slot_idx   (slot_idx)
);

// File: tb/test_pixlink_ser.sv
module test_pixlink_ser;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        bit_clk = 1'b0;
  logic        rst = 1'b1;
  logic        pwr_n = 1'b1;
  logic        edge_sel = 1'b1;
  logic        pix_strobe = 1'b0;
  logic [27:0] pix_word = '0;
  logic [3:0]  lane_o;
  logic        clk_lane_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  logic prev_clk = 1'b0;
  logic cur_clk  = 1'b0;
  logic [27:0] exp_cur = '0;

  // Expected bit placement per lane and slot (R3, R4, R5, R6)
  int src_map [4][7] = '{
    '{7, 6, 4, 3, 2, 1, 0},
    '{18, 15, 14, 13, 12, 9, 8},
    '{26, 25, 24, 22, 21, 20, 19},
    '{23, 17, 16, 11, 10, 5, 27}
  };

  always #(CLK_PERIOD/2) bit_clk = ~bit_clk;

  pixlink_ser i_pixlink_ser (
    .bit_clk    (bit_clk),
    .rst        (rst),
    .pwr_n      (pwr_n),
    .edge_sel   (edge_sel),
    .pix_strobe (pix_strobe),
    .pix_word   (pix_word),
    .lane_o     (lane_o),
    .clk_lane_o (clk_lane_o)
  );

  always @(posedge bit_clk) begin
    cycles++;
    if (cycles >= WATCHDOG) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual %0d cycles, expected fewer than %0d", cycles, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic tick();
    @(negedge bit_clk);
    prev_clk = cur_clk;
    cur_clk  = clk_lane_o;
  endtask

  task automatic chk_slot(input logic [27:0] w, input int s, input string why);
    logic [4:0] exp_v;
    logic [4:0] got_v;
    exp_v[4] = (s < 4);
    for (int l = 0; l < 4; l++) exp_v[l] = w[src_map[l][s]];
    got_v = {clk_lane_o, lane_o};
    n_tests++;
    if (got_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s slot %0d: actual %b, expected %b", why, s, got_v, exp_v);
    end
  endtask

  task automatic chk_quiet(input string why);
    n_tests++;
    if ({clk_lane_o, lane_o} !== 5'b0) begin
      n_fail++;
      $display("FAIL %s: actual %b, expected 00000", why, {clk_lane_o, lane_o});
    end
  endtask

  // Present word w with strobe moved to lvl at the start of a period; cap says whether
  // the selected edge is expected to capture it (R7). The running period keeps the
  // old word (R10); the next one carries the expected word (R1..R6).
  task automatic send(input logic [27:0] w, input logic lvl, input bit cap);
    do tick(); while (!(cur_clk && !prev_clk));
    pix_word   = w;
    pix_strobe = lvl;
    for (int s = 1; s < 7; s++) begin
      tick();
      chk_slot(exp_cur, s, "R10 old word intact mid-period");
    end
    if (cap) exp_cur = w;
    for (int s = 0; s < 7; s++) begin
      tick();
      chk_slot(exp_cur, s, cap ? "R7 capture R1 R2 R3 R4 R5 R6 lane map"
                                : "R7 ignored edge");
    end
  endtask

  initial begin
    // R9: reset holds outputs low, then restarts at slot 0 with zero data
    tick();
    tick();
    chk_quiet("R9 outputs during reset");
    rst = 1'b0;
    tick();
    chk_slot(28'h0, 0, "R9 first slot after reset");

    // Rising-edge mode: walking one captured, complement on falling edge ignored
    edge_sel = 1'b1;
    for (int i = 0; i < 28; i++) begin
      send(28'h1 << i, 1'b1, 1'b1);
      send(~(28'h1 << i), 1'b0, 1'b0);
    end

    // Falling-edge mode: rising edge ignored, falling edge captured
    edge_sel = 1'b0;
    for (int i = 0; i < 28; i++) begin
      send(28'h1 << i, 1'b1, 1'b0);
      send(~(28'h1 << i) ^ (28'h5A5A5A5 << (i % 3)), 1'b0, 1'b1);
    end
    send(28'hFFFFFFF, 1'b1, 1'b0);
    send(28'hFFFFFFF, 1'b0, 1'b1);
    send(28'hAAAAAAA, 1'b1, 1'b0);
    send(28'hAAAAAAA, 1'b0, 1'b1);

    // R9: reset in mid-stream
    tick();
    tick();
    rst = 1'b1;
    tick();
    chk_quiet("R9 outputs one clock into mid-stream reset");
    tick();
    rst = 1'b0;
    tick();
    chk_slot(28'h0, 0, "R9 restart at slot 0 after mid-stream reset");
    exp_cur = '0;
    send(28'h1234567, 1'b1, 1'b0);
    send(28'h1234567, 1'b0, 1'b1);

    // R8: power-down, with a selected edge presented while off
    edge_sel = 1'b1;
    tick();
    tick();
    pwr_n = 1'b0;
    for (int k = 0; k < 5; k++) begin
      tick();
      chk_quiet("R8 outputs while powered down");
      if (k == 1) begin
        pix_word   = 28'h7654321;
        pix_strobe = 1'b1;
      end
      if (k == 3) pix_strobe = 1'b0;
    end
    pwr_n = 1'b1;
    tick();
    chk_slot(28'h0, 0, "R8 first slot after power-up, word cleared");
    exp_cur = '0;
    for (int s = 1; s < 7; s++) begin
      tick();
      chk_slot(28'h0, s, "R8 zero word after power-up");
    end
    send(28'hC3C3C3C, 1'b1, 1'b1);
    send(28'h3C3C3C3, 1'b0, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule